// File: doc/BRIEF.md
# Age-gated hint release buffer

This block sits between a run-ahead producer core and the consumer core that it accelerates. The producer pushes hint records into one shared in-order queue. Each record is stamped with the producer's committed-instruction count at the moment the queue accepts it. The block also counts the instructions that the consumer commits. The record at the head of the queue is released only once its stamp has come within a programmable window of the consumer's count. The producer cannot run too far ahead, and a stale hint is never applied before its time.

A released hint is steered by its type to one of three output ports, each with a valid/ready handshake. The instruction-prefetch port carries an instruction address. The data-prefetch port carries a load or store address. The branch-update port carries a PC and a next-PC. A per-type kill input drops hints of that type at the head without blocking the queue. A resynchronization pulse flushes every held hint and restarts both instruction counters from zero.

Top module: `hint_release_buf`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, hint_ready_o is 1 and all three output valids are 0.
- R2: All hint types share one FIFO and leave it in push order. A hint behind a head that has not been released is not presented on any port, even if it is itself eligible.
- R3: The head hint is presented only when its age is less than or equal to the consumer count plus window_i. The sum is computed without overflow. An age one above that limit holds the hint back.
- R4: An accepted hint takes as its age the producer count before that cycle's increment. The producer count rises by one in every cycle with prod_commit_i high, and the consumer count rises by one in every cycle with cons_commit_i high.
- R5: hint_type_i selects the port: 2'b00 goes to the instruction-prefetch port (ipf_addr_o = PC), 2'b01 goes to the data-prefetch port (dpf_addr_o = PC field), and 2'b10 goes to the branch port (bp_pc_o = PC, bp_npc_o = next-PC).
- R6: hint_kill_i bit k (bit 0 instruction prefetch, bit 1 data prefetch, bit 2 branch) drops a head hint of type k in one cycle, whatever its age, with no output valid. Hints of other types are not affected.
- R7: Type 2'b11 is reserved. Such a hint is dropped at the head in one cycle with no output valid.
- R8: The FIFO holds DEPTH (16) entries. When it is full, hint_ready_o is 0 and no push is taken. A pop reopens it.
- R9: In a cycle with resync_i high, hint_ready_o is 0 and no output valid is raised. By the next cycle the FIFO is empty and both counters are zero.
- R10: At most one output valid is high in any cycle. A presented hint keeps its valid and its payload until it is accepted, unless a resync, a kill change or a window change intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hint_valid_i | input | 1 | Producer offers a hint |
| hint_ready_o | output | 1 | Queue accepts the hint |
| hint_type_i | input | 2 | Hint type code |
| hint_pc_i | input | PC_W | PC or data address |
| hint_npc_i | input | PC_W | Next-PC for branch hints |
| prod_commit_i | input | 1 | Producer committed one instruction |
| cons_commit_i | input | 1 | Consumer committed one instruction |
| window_i | input | AGE_W | Release window added to the consumer count |
| resync_i | input | 1 | Flush the queue and clear the counters |
| hint_kill_i | input | 3 | Per-type drop enables |
| ipf_valid_o | output | 1 | Instruction-prefetch hint valid |
| ipf_ready_i | input | 1 | Instruction-prefetch sink ready |
| ipf_addr_o | output | PC_W | Instruction-prefetch address |
| dpf_valid_o | output | 1 | Data-prefetch hint valid |
| dpf_ready_i | input | 1 | Data-prefetch sink ready |
| dpf_addr_o | output | PC_W | Data-prefetch address |
| bp_valid_o | output | 1 | Branch update valid |
| bp_ready_i | input | 1 | Predictor ready |
| bp_pc_o | output | PC_W | Branch PC |
| bp_npc_o | output | PC_W | Branch next-PC |

## Verification
A resync can land in the same cycle as a release that would otherwise complete, and in the same cycle as a new push. The bench makes a head hint eligible, then raises resync_i together with the port's ready and a fresh push. In that cycle it expects neither a valid nor a producer ready. Afterwards it pushes a new hint under a zero window, and that hint must appear at once with age zero. This shows that the queued hint and the colliding push are both gone and that the producer count was cleared.

// File: rtl/hint_pkg.sv
package hint_pkg;
  parameter int unsigned PC_W   = 32;
  parameter int unsigned AGE_W  = 16;
  parameter int unsigned N_PORT = 3;

  typedef enum logic [1:0] {
    HT_IPF = 2'd0,
    HT_DPF = 2'd1,
    HT_BP  = 2'd2,
    HT_RSV = 2'd3
  } hint_type_e;

  typedef struct packed {
    hint_type_e       kind;
    logic [AGE_W-1:0] age;
    logic [PC_W-1:0]  pc;
    logic [PC_W-1:0]  npc;
  } hint_rec_t;
endpackage

// File: rtl/hint_age_ctr.sv
module hint_age_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/hint_fifo.sv
module hint_fifo import hint_pkg::*; #(
  parameter int unsigned DEPTH = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      flush_i,
  input  logic      push_i,
  input  hint_rec_t din_i,
  input  logic      pop_i,
  output logic      full_o,
  output logic      empty_o,
  output hint_rec_t head_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = PTR_W + 1;

  hint_rec_t        mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign head_o  = mem[rptr_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/hint_router.sv
module hint_router import hint_pkg::*; (
  input  logic              head_vld_i,
  input  hint_type_e        head_kind_i,
  input  logic [AGE_W-1:0]  head_age_i,
  input  logic [AGE_W-1:0]  cons_cnt_i,
  input  logic [AGE_W-1:0]  window_i,
  input  logic [N_PORT-1:0] kill_i,
  input  logic              flush_i,
  input  logic [N_PORT-1:0] rdy_i,
  output logic [N_PORT-1:0] vld_o,
  output logic              pop_o
);
  logic [AGE_W:0]    limit;
  logic              age_ok, is_rsv, killed, live;
  logic [N_PORT-1:0] match;

  assign limit  = {1'b0, cons_cnt_i} + {1'b0, window_i};
  assign age_ok = ({1'b0, head_age_i} <= limit);
  assign is_rsv = (head_kind_i == HT_RSV);
  assign live   = head_vld_i && !flush_i;

  for (genvar t = 0; t < N_PORT; t++) begin : g_port
    assign match[t] = (head_kind_i == hint_type_e'(t));
    assign vld_o[t] = live && age_ok && match[t] && !kill_i[t];
  end

  assign killed = is_rsv || |(match & kill_i);
  // dropped hints leave regardless of age so they never stall the queue
  assign pop_o  = live && (killed || |(vld_o & rdy_i));
endmodule

// File: rtl/hint_release_buf.sv
module hint_release_buf import hint_pkg::*; #(
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hint_valid_i,
  output logic             hint_ready_o,
  input  logic [1:0]       hint_type_i,
  input  logic [PC_W-1:0]  hint_pc_i,
  input  logic [PC_W-1:0]  hint_npc_i,
  input  logic             prod_commit_i,
  input  logic             cons_commit_i,
  input  logic [AGE_W-1:0] window_i,
  input  logic             resync_i,
  input  logic [2:0]       hint_kill_i,
  output logic             ipf_valid_o,
  input  logic             ipf_ready_i,
  output logic [PC_W-1:0]  ipf_addr_o,
  output logic             dpf_valid_o,
  input  logic             dpf_ready_i,
  output logic [PC_W-1:0]  dpf_addr_o,
  output logic             bp_valid_o,
  input  logic             bp_ready_i,
  output logic [PC_W-1:0]  bp_pc_o,
  output logic [PC_W-1:0]  bp_npc_o
);
  logic [AGE_W-1:0]  prod_cnt, cons_cnt;
  logic              full_w, empty_w, push_w, pop_w;
  hint_rec_t         rec_in, head_rec;
  logic [N_PORT-1:0] vld_w, rdy_w;

  hint_age_ctr #(.W(AGE_W)) u_prod_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(resync_i),
    .inc_i(prod_commit_i), .cnt_o(prod_cnt)
  );

  hint_age_ctr #(.W(AGE_W)) u_cons_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(resync_i),
    .inc_i(cons_commit_i), .cnt_o(cons_cnt)
  );

  assign hint_ready_o = !full_w && !resync_i;
  assign push_w       = hint_valid_i && hint_ready_o;

  always_comb begin
    rec_in.kind = hint_type_e'(hint_type_i);
    rec_in.age  = prod_cnt;
    rec_in.pc   = hint_pc_i;
    rec_in.npc  = hint_npc_i;
  end

  hint_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(resync_i),
    .push_i(push_w), .din_i(rec_in), .pop_i(pop_w),
    .full_o(full_w), .empty_o(empty_w), .head_o(head_rec)
  );

  assign rdy_w = {bp_ready_i, dpf_ready_i, ipf_ready_i};

  hint_router u_router (
    .head_vld_i(!empty_w), .head_kind_i(head_rec.kind), .head_age_i(head_rec.age),
    .cons_cnt_i(cons_cnt), .window_i(window_i), .kill_i(hint_kill_i),
    .flush_i(resync_i), .rdy_i(rdy_w), .vld_o(vld_w), .pop_o(pop_w)
  );

  assign ipf_valid_o = vld_w[HT_IPF];
  assign dpf_valid_o = vld_w[HT_DPF];
  assign bp_valid_o  = vld_w[HT_BP];
  assign ipf_addr_o  = head_rec.pc;
  assign dpf_addr_o  = head_rec.pc;
  assign bp_pc_o     = head_rec.pc;
  assign bp_npc_o    = head_rec.npc;
endmodule

// File: rtl/hint_release_buf_chk.sv
module hint_release_buf_chk import hint_pkg::*; #(
  parameter int unsigned DEPTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hint_valid_i,
  input logic             hint_ready_o,
  input logic             cons_commit_i,
  input logic [AGE_W-1:0] window_i,
  input logic             resync_i,
  input logic [2:0]       hint_kill_i,
  input logic [2:0]       vld_i,
  input logic [2:0]       rdy_i,
  input logic             pop_i,
  input logic [AGE_W-1:0] head_age_i,
  input logic [PC_W-1:0]  bp_pc_i
);
  localparam int unsigned OCC_W = $clog2(DEPTH) + 2;

  logic [AGE_W-1:0] cons_q;
  logic [OCC_W-1:0] occ_q;
  logic             push;

  assign push = hint_valid_i && hint_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cons_q <= '0;
      occ_q  <= '0;
    end else if (resync_i) begin
      cons_q <= '0;
      occ_q  <= '0;
    end else begin
      cons_q <= cons_q + AGE_W'(cons_commit_i);
      occ_q  <= occ_q + OCC_W'(push) - OCC_W'(pop_i);
    end
  end

  AST_AGE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|vld_i) |-> ({1'b0, head_age_i} <= {1'b0, cons_q} + {1'b0, window_i})); // R3
  AST_ONE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vld_i)); // R10
  AST_HOLD_BP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i[2] && !rdy_i[2]) |=> ((vld_i[2] && $stable(bp_pc_i)) || resync_i
                                  || !$stable(hint_kill_i) || !$stable(window_i))); // R10
  AST_FULL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == OCC_W'(DEPTH)) |-> !hint_ready_o); // R8
  AST_OCC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= OCC_W'(DEPTH)); // R8
  AST_RESYNC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |-> (vld_i == 3'b000 && !hint_ready_o)); // R9
  AST_RESYNC_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> (vld_i == 3'b000)); // R9
endmodule

bind hint_release_buf hint_release_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hint_valid_i(hint_valid_i),
  .hint_ready_o(hint_ready_o), .cons_commit_i(cons_commit_i),
  .window_i(window_i), .resync_i(resync_i), .hint_kill_i(hint_kill_i),
  .vld_i({bp_valid_o, dpf_valid_o, ipf_valid_o}),
  .rdy_i({bp_ready_i, dpf_ready_i, ipf_ready_i}),
  .pop_i(pop_w), .head_age_i(head_rec.age), .bp_pc_i(bp_pc_o)
);

// File: tb/hint_release_buf_tb_top.sv
module hint_release_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hint_valid_i = 1'b0, hint_ready_o;
  logic [1:0]  hint_type_i = '0;
  logic [31:0] hint_pc_i = '0, hint_npc_i = '0;
  logic        prod_commit_i = 1'b0, cons_commit_i = 1'b0;
  logic [15:0] window_i = '0;
  logic        resync_i = 1'b0;
  logic [2:0]  hint_kill_i = '0;
  logic        ipf_valid_o, dpf_valid_o, bp_valid_o;
  logic        ipf_ready_i = 1'b0, dpf_ready_i = 1'b0, bp_ready_i = 1'b0;
  logic [31:0] ipf_addr_o, dpf_addr_o, bp_pc_o, bp_npc_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  hint_release_buf dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hint_valid_i(hint_valid_i), .hint_ready_o(hint_ready_o),
    .hint_type_i(hint_type_i), .hint_pc_i(hint_pc_i), .hint_npc_i(hint_npc_i),
    .prod_commit_i(prod_commit_i), .cons_commit_i(cons_commit_i), .window_i(window_i),
    .resync_i(resync_i), .hint_kill_i(hint_kill_i),
    .ipf_valid_o(ipf_valid_o), .ipf_ready_i(ipf_ready_i), .ipf_addr_o(ipf_addr_o),
    .dpf_valid_o(dpf_valid_o), .dpf_ready_i(dpf_ready_i), .dpf_addr_o(dpf_addr_o),
    .bp_valid_o(bp_valid_o), .bp_ready_i(bp_ready_i), .bp_pc_o(bp_pc_o), .bp_npc_o(bp_npc_o)
  );

  // {type, kill, expected port (3 = none)}
  localparam logic [6:0] VECS [8] = '{
    {2'd0, 3'b000, 2'd0},
    {2'd1, 3'b000, 2'd1},
    {2'd2, 3'b000, 2'd2},
    {2'd3, 3'b000, 2'd3},
    {2'd0, 3'b001, 2'd3},
    {2'd1, 3'b001, 2'd1},
    {2'd2, 3'b100, 2'd3},
    {2'd2, 3'b011, 2'd2}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] vlds();
    return {bp_valid_o, dpf_valid_o, ipf_valid_o};
  endfunction

  task automatic push(input logic [1:0] t, input logic [31:0] pc);
    hint_valid_i = 1'b1;
    hint_type_i  = t;
    hint_pc_i    = pc;
    hint_npc_i   = pc + 32'd4;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk(hint_ready_o == 1'b1, "R1 ready in reset", 32'(hint_ready_o), 32'd1);
    chk(vlds() == 3'b000, "R1 valids in reset", 32'(vlds()), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    window_i = 16'd100;
    {bp_ready_i, dpf_ready_i, ipf_ready_i} = 3'b111;
    #1;
    chk(vlds() == 3'b000 && hint_ready_o, "R1 after reset", 32'({hint_ready_o, vlds()}), 32'h8);

    // table: routing, kill and reserved type (R5, R6, R7)
    for (int i = 0; i < 8; i++) begin
      logic [31:0] pc;
      logic [1:0]  port;
      logic [2:0]  expv;
      pc   = 32'h1000 + 32'(i) * 32'h10;
      port = VECS[i][1:0];
      expv = (port == 2'd3) ? 3'b000 : 3'(1 << port);
      @(negedge clk);
      push(VECS[i][6:5], pc);
      hint_kill_i = VECS[i][4:2];
      #1;
      chk(vlds() == 3'b000, "R2 queue empty before push", 32'(vlds()), 32'd0);
      @(negedge clk);
      hint_valid_i = 1'b0;
      #1;
      chk(vlds() == expv, (port == 2'd3) ? "R6/R7 dropped" : "R5 route", 32'(vlds()), 32'(expv));
      if (port == 2'd0) chk(ipf_addr_o == pc, "R5 ipf addr", ipf_addr_o, pc);
      if (port == 2'd1) chk(dpf_addr_o == pc, "R5 dpf addr", dpf_addr_o, pc);
      if (port == 2'd2) chk(bp_pc_o == pc && bp_npc_o == pc + 32'd4, "R5 bp pc/npc", bp_npc_o, pc + 32'd4);
    end
    @(negedge clk);
    hint_kill_i = 3'b000;
    #1;
    chk(vlds() == 3'b000, "R6 dropped hints left the queue", 32'(vlds()), 32'd0);

    // age window (R2, R3, R4)
    {bp_ready_i, dpf_ready_i, ipf_ready_i} = 3'b000;
    window_i = 16'd0;
    resync_i = 1'b1;
    @(negedge clk);
    resync_i = 1'b0;
    prod_commit_i = 1'b1;
    repeat (3) @(negedge clk);
    prod_commit_i = 1'b0;
    push(2'd0, 32'hA000);
    @(negedge clk);
    push(2'd1, 32'hB000);
    prod_commit_i = 1'b1;
    @(negedge clk);
    hint_valid_i = 1'b0;
    prod_commit_i = 1'b0;
    #1;
    chk(vlds() == 3'b000, "R3 age 3 above limit 0", 32'(vlds()), 32'd0);
    window_i = 16'd2;
    #1;
    chk(ipf_valid_o == 1'b0, "R3 age one above limit", 32'(ipf_valid_o), 32'd0);
    window_i = 16'd3;
    #1;
    chk(ipf_valid_o == 1'b1, "R3 age equal to limit", 32'(ipf_valid_o), 32'd1);
    window_i = 16'd2;
    cons_commit_i = 1'b1;
    @(negedge clk);
    cons_commit_i = 1'b0;
    #1;
    chk(ipf_valid_o == 1'b1 && ipf_addr_o == 32'hA000, "R4 consumer count raised", ipf_addr_o, 32'hA000);
    chk(dpf_valid_o == 1'b0, "R2 younger hint held behind head", 32'(dpf_valid_o), 32'd0);
    ipf_ready_i = 1'b1;
    @(negedge clk);
    ipf_ready_i = 1'b0;
    #1;
    chk(dpf_valid_o == 1'b1 && dpf_addr_o == 32'hB000, "R4 age stamped before increment", dpf_addr_o, 32'hB000);
    dpf_ready_i = 1'b1;
    @(negedge clk);
    dpf_ready_i = 1'b0;
    #1;
    chk(vlds() == 3'b000, "R2 queue drained", 32'(vlds()), 32'd0);

    // full queue (R8)
    window_i = 16'd100;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      push(2'd0, 32'h2000 + 32'(k) * 32'd4);
    end
    @(negedge clk);
    push(2'd0, 32'hDEAD0);
    #1;
    chk(hint_ready_o == 1'b0, "R8 ready low when full", 32'(hint_ready_o), 32'd0);
    @(negedge clk);
    hint_valid_i = 1'b0;
    ipf_ready_i = 1'b1;
    for (int k = 0; k < 16; k++) begin
      #1;
      chk(ipf_valid_o && ipf_addr_o == 32'h2000 + 32'(k) * 32'd4, "R8 order after full",
          ipf_addr_o, 32'h2000 + 32'(k) * 32'd4);
      if (k == 1) chk(hint_ready_o == 1'b1, "R8 ready after pop", 32'(hint_ready_o), 32'd1);
      @(negedge clk);
    end
    ipf_ready_i = 1'b0;
    #1;
    chk(vlds() == 3'b000, "R8 push on full not stored", 32'(vlds()), 32'd0);

    // resync colliding with a release and a push (R9)
    window_i = 16'd0;
    prod_commit_i = 1'b1;
    repeat (2) @(negedge clk);
    prod_commit_i = 1'b0;
    push(2'd0, 32'hC000);
    @(negedge clk);
    hint_valid_i = 1'b0;
    window_i = 16'd5;
    #1;
    chk(ipf_valid_o == 1'b1, "R3 eligible before resync", 32'(ipf_valid_o), 32'd1);
    @(negedge clk);
    ipf_ready_i = 1'b1;
    resync_i = 1'b1;
    push(2'd2, 32'hD000);
    #1;
    chk(vlds() == 3'b000 && !hint_ready_o, "R9 quiet during resync", 32'({hint_ready_o, vlds()}), 32'd0);
    @(negedge clk);
    resync_i = 1'b0;
    hint_valid_i = 1'b0;
    ipf_ready_i = 1'b0;
    window_i = 16'd0;
    #1;
    chk(vlds() == 3'b000, "R9 flushed", 32'(vlds()), 32'd0);
    push(2'd2, 32'hE000);
    @(negedge clk);
    hint_valid_i = 1'b0;
    #1;
    chk(bp_valid_o == 1'b1 && bp_pc_o == 32'hE000, "R9 producer count cleared", bp_pc_o, 32'hE000);
    bp_ready_i = 1'b1;
    @(negedge clk);
    bp_ready_i = 1'b0;
    #1;
    chk(vlds() == 3'b000, "R9 colliding push dropped", 32'(vlds()), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule